// File: doc/BRIEF.md
# Hypervisor-Aware Trap Routing Unit

This block decides which privilege level takes a trap on a hart that has the hypervisor extension. It then works out the status-field updates that go with that choice. The pipeline presents a trap for one cycle: the trap class (interrupt or exception), its cause code, the hart's current privilege and virtualization state, the force-HS flag, the four delegation masks, and a packed word that holds the current supervisor, machine and hypervisor status fields. One clock edge later the unit presents the following results and holds them until the next trap:

- the final cause word;
- the new privilege, virtualization and force-HS state;
- the updated status word;
- a one-cycle request to exchange the hypervisor register banks.

Routing works in two stages. The machine-level masks first choose between M-level and S-level. For a trap that goes to S-level, the hypervisor masks and the force-HS override then choose between staying in the guest (VS) and leaving to the host (HS). Environment calls arrive with one shared cause code. The unit re-encodes that code from the privilege and virtualization state, and the re-encoded value is the one used for delegation. A parameter removes all hypervisor behaviour for harts that lack the extension.

Top module: `trap_route_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the outputs become: done_o=0, swap_o=0, priv_o=3 (M), virt_o=0, force_hs_o=0, cause_o=0, st_o=0. The privilege encoding is U=0, S=1, M=3.
- R2: A synchronous trap (async_i=0) with cause 8 is an environment call, and its code is replaced according to the current privilege: 11 from M, 9 from S with virtualization off, 10 from S with virtualization on, and 8 from U.
- R3: cause_o carries the (possibly re-encoded) code zero-extended in its low bits, with async_i placed in bit XLEN-1.
- R4: The mask is mideleg_i for interrupts and medeleg_i for exceptions. A trap goes to S-level only when priv_i is U or S, the code is below XLEN, and the mask bit indexed by the code is 1. Every other trap goes to M-level.
- R5: An S-level trap stays in the guest (priv_o=S, virt_o=1, no swap, hypervisor fields unchanged) only when virt_i=1, force_hs_i=0, and the matching bit of hideleg_i (interrupts) or hedeleg_i (exceptions) is 1.
- R6: An S-level trap from a virtualized context that does not stay in the guest makes the following updates: swap_o pulses; sp2v takes the old spv; sp2p takes the old spp; spv becomes 1; stl takes force_hs_i; virt_o becomes 0 and force_hs_o becomes 0.
- R7: An S-level trap from a non-virtualized context makes the same sp2v, sp2p and spv updates as R6, with spv becoming 0. It does not pulse swap_o and does not change stl or force_hs_o.
- R8: Every S-level trap sets spie to the old sie, sets spp to 1 exactly when the old privilege was S, and sets priv_o to S.
- R9: An M-level trap sets mpie to the old mie, mpp to priv_i, and priv_o to M. With the extension present it also sets mpv to virt_i and mtl to force_hs_i, clears virt_o, keeps force_hs_o, and pulses swap_o exactly when virt_i was 1.
- R10: done_o is 1 in the cycle after each cycle in which trap_valid_i is 1, and 0 otherwise. Without a trap, every other output keeps its value. swap_o is never 1 when done_o is 0.
- R11: With HYP_EN=0, virt_i is treated as 0. The VS check, the spv/sp2v/sp2p/stl/mpv/mtl updates and swap_o are all disabled, and virt_o and force_hs_o are 0 after any trap.
- R12: The status word uses this layout: bit0 sie, bit1 spie, bit2 spp, bit3 mie, bit4 mpie, bits6:5 mpp, bit7 mpv, bit8 mtl, bit9 spv, bit10 sp2v, bit11 sp2p, bit12 stl. Any field that the applicable rule does not name is copied from st_i to st_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_valid_i | input | 1 | One-cycle trap strobe |
| async_i | input | 1 | 1 for interrupt, 0 for exception |
| cause_i | input | CAUSE_W | Cause code without the interrupt bit |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| virt_i | input | 1 | Current virtualization state |
| force_hs_i | input | 1 | Force the trap to the host supervisor |
| mideleg_i | input | XLEN | Machine interrupt delegation mask |
| medeleg_i | input | XLEN | Machine exception delegation mask |
| hideleg_i | input | XLEN | Hypervisor interrupt delegation mask |
| hedeleg_i | input | XLEN | Hypervisor exception delegation mask |
| st_i | input | 13 | Current status fields (layout in R12) |
| done_o | output | 1 | Results updated this cycle |
| cause_o | output | XLEN | Reported cause word |
| priv_o | output | 2 | New privilege |
| virt_o | output | 1 | New virtualization state |
| force_hs_o | output | 1 | New force-HS state |
| st_o | output | 13 | Updated status fields |
| swap_o | output | 1 | Request to exchange hypervisor register banks |

## Verification
Directed vectors cover each of the following: an environment call from each privilege; a code at XLEN-1 against one at XLEN with every mask bit set; an interrupt that stays in the guest against the same interrupt with force-HS raised; and traps from M with every mask bit set. Together these separate the re-encoding, the range check and the override. Random vectors mix the two trap classes, all three privileges, sparse and dense masks, and random status words, so that copying of untouched fields is exercised. Two instances, one with the extension enabled and one with it removed, receive identical stimulus, which tells hypervisor-only updates apart from the common supervisor and machine updates. Idle cycles with changing inputs confirm that results hold between traps.

// File: rtl/trap_route_pkg.sv
// Shared encodings for the trap routing unit.
// Assumes a two-bit privilege field and the packed status layout below.
package trap_route_pkg;

    localparam int ST_W = 13;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    // Packed status word; bit 0 is sie, bit 12 is stl.
    typedef struct packed {
        logic       stl;
        logic       sp2p;
        logic       sp2v;
        logic       spv;
        logic       mtl;
        logic       mpv;
        logic [1:0] mpp;
        logic       mpie;
        logic       mie;
        logic       spp;
        logic       spie;
        logic       sie;
    } st_t;

    localparam int EC_FROM_U  = 8;
    localparam int EC_FROM_HS = 9;
    localparam int EC_FROM_VS = 10;
    localparam int EC_FROM_M  = 11;

endpackage

// File: rtl/trap_cause_map.sv
// Re-encodes environment-call causes from privilege and virtualization
// state, and forms the reported cause word with the interrupt flag on top.
// Assumes CAUSE_W < XLEN and CAUSE_W >= 4.
module trap_cause_map #(
    parameter int XLEN    = 64,
    parameter int CAUSE_W = 8
) (
    input  logic               async_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [1:0]         priv_i,
    input  logic               virt_i,
    output logic [CAUSE_W-1:0] code_o,
    output logic [XLEN-1:0]    word_o
);
    import trap_route_pkg::*;

    localparam logic [CAUSE_W-1:0] C_U  = CAUSE_W'(EC_FROM_U);
    localparam logic [CAUSE_W-1:0] C_HS = CAUSE_W'(EC_FROM_HS);
    localparam logic [CAUSE_W-1:0] C_VS = CAUSE_W'(EC_FROM_VS);
    localparam logic [CAUSE_W-1:0] C_M  = CAUSE_W'(EC_FROM_M);

    // Pick the environment-call code for the current mode.
    always_comb begin
        code_o = cause_i;
        if (!async_i && cause_i == C_U) begin
            unique case (priv_i)
                PRIV_M:  code_o = C_M;
                PRIV_S:  code_o = virt_i ? C_VS : C_HS;
                default: code_o = C_U;
            endcase
        end
    end

    // Zero-extend the code and put the interrupt flag in the top bit.
    always_comb begin
        word_o                = '0;
        word_o[CAUSE_W-1:0]   = code_o;
        word_o[XLEN-1]        = async_i;
    end

endmodule

// File: rtl/trap_level_sel.sv
// Two-stage delegation decision: machine masks choose S-level versus
// M-level, then hypervisor masks and force-HS choose guest versus host.
// Assumes XLEN is a power of two and CAUSE_W >= log2(XLEN).
module trap_level_sel #(
    parameter int XLEN    = 64,
    parameter int CAUSE_W = 8,
    parameter bit HYP_EN  = 1'b1
) (
    input  logic               async_i,
    input  logic [CAUSE_W-1:0] code_i,
    input  logic [1:0]         priv_i,
    input  logic               virt_i,
    input  logic               force_hs_i,
    input  logic [XLEN-1:0]    mideleg_i,
    input  logic [XLEN-1:0]    medeleg_i,
    input  logic [XLEN-1:0]    hideleg_i,
    input  logic [XLEN-1:0]    hedeleg_i,
    output logic               to_s_o,
    output logic               to_vs_o
);
    import trap_route_pkg::*;

    localparam int IDX_W = $clog2(XLEN);

    logic            in_range;
    logic [IDX_W-1:0] idx;
    logic [XLEN-1:0] m_mask;
    logic [XLEN-1:0] h_mask;

    // Select masks by trap class and bound the index.
    always_comb begin
        in_range = (32'(code_i) < 32'(XLEN));
        idx      = code_i[IDX_W-1:0];
        m_mask   = async_i ? mideleg_i : medeleg_i;
        h_mask   = async_i ? hideleg_i : hedeleg_i;
    end

    // First stage: machine-level delegation.
    always_comb begin
        to_s_o = (priv_i == PRIV_U || priv_i == PRIV_S) && in_range && m_mask[idx];
    end

    // Second stage: stay in the guest only when the extension exists.
    generate
        if (HYP_EN) begin : g_hyp
            always_comb begin
                to_vs_o = to_s_o && virt_i && h_mask[idx] && !force_hs_i;
            end
        end else begin : g_nohyp
            always_comb begin
                to_vs_o = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/trap_state_next.sv
// Computes the next privilege, virtualization, force-HS and status fields
// for a trap whose destination level is already decided.
// Assumes virt_i is already forced low when HYP_EN is 0.
module trap_state_next #(
    parameter bit HYP_EN = 1'b1
) (
    input  logic                            to_s_i,
    input  logic                            to_vs_i,
    input  logic [1:0]                      priv_i,
    input  logic                            virt_i,
    input  logic                            force_hs_i,
    input  logic [trap_route_pkg::ST_W-1:0] st_i,
    output logic [1:0]                      priv_o,
    output logic                            virt_o,
    output logic                            force_hs_o,
    output logic [trap_route_pkg::ST_W-1:0] st_o,
    output logic                            swap_o
);
    import trap_route_pkg::*;

    st_t cur;
    st_t nxt;

    assign cur  = st_t'(st_i);
    assign st_o = ST_W'(nxt);

    // Apply the update set for the chosen destination.
    always_comb begin
        nxt        = cur;
        priv_o     = priv_i;
        virt_o     = 1'b0;
        force_hs_o = HYP_EN ? force_hs_i : 1'b0;
        swap_o     = 1'b0;
        if (to_s_i) begin
            if (to_vs_i) begin
                virt_o = 1'b1;
            end else if (HYP_EN) begin
                nxt.sp2v = cur.spv;
                nxt.sp2p = cur.spp;
                nxt.spv  = virt_i;
                if (virt_i) begin
                    nxt.stl    = force_hs_i;
                    swap_o     = 1'b1;
                    force_hs_o = 1'b0;
                end
            end
            nxt.spie = cur.sie;
            nxt.spp  = (priv_i == PRIV_S);
            priv_o   = PRIV_S;
        end else begin
            if (HYP_EN) begin
                swap_o  = virt_i;
                nxt.mpv = virt_i;
                nxt.mtl = force_hs_i;
            end
            nxt.mpie = cur.mie;
            nxt.mpp  = priv_i;
            priv_o   = PRIV_M;
        end
    end

endmodule

// File: rtl/trap_route_unit.sv
// Top of the trap routing unit: maps the cause, decides the level,
// computes the new state and registers everything on a trap strobe.
// Assumes trap_valid_i is a single-cycle pulse per trap.
module trap_route_unit #(
    parameter int XLEN    = 64,
    parameter int CAUSE_W = 8,
    parameter bit HYP_EN  = 1'b1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            trap_valid_i,
    input  logic                            async_i,
    input  logic [CAUSE_W-1:0]              cause_i,
    input  logic [1:0]                      priv_i,
    input  logic                            virt_i,
    input  logic                            force_hs_i,
    input  logic [XLEN-1:0]                 mideleg_i,
    input  logic [XLEN-1:0]                 medeleg_i,
    input  logic [XLEN-1:0]                 hideleg_i,
    input  logic [XLEN-1:0]                 hedeleg_i,
    input  logic [trap_route_pkg::ST_W-1:0] st_i,
    output logic                            done_o,
    output logic [XLEN-1:0]                 cause_o,
    output logic [1:0]                      priv_o,
    output logic                            virt_o,
    output logic                            force_hs_o,
    output logic [trap_route_pkg::ST_W-1:0] st_o,
    output logic                            swap_o
);
    import trap_route_pkg::*;

    logic               virt_eff;
    logic [CAUSE_W-1:0] code;
    logic [XLEN-1:0]    word;
    logic               to_s;
    logic               to_vs;
    logic [1:0]         priv_nx;
    logic               virt_nx;
    logic               force_nx;
    logic [ST_W-1:0]    st_nx;
    logic               swap_nx;

    // Ignore the virtualization input when the extension is absent.
    generate
        if (HYP_EN) begin : g_virt
            assign virt_eff = virt_i;
        end else begin : g_novirt
            assign virt_eff = 1'b0;
        end
    endgenerate

    trap_cause_map #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_map (
        .async_i (async_i),
        .cause_i (cause_i),
        .priv_i  (priv_i),
        .virt_i  (virt_eff),
        .code_o  (code),
        .word_o  (word)
    );

    trap_level_sel #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .HYP_EN(HYP_EN)) u_sel (
        .async_i    (async_i),
        .code_i     (code),
        .priv_i     (priv_i),
        .virt_i     (virt_eff),
        .force_hs_i (force_hs_i),
        .mideleg_i  (mideleg_i),
        .medeleg_i  (medeleg_i),
        .hideleg_i  (hideleg_i),
        .hedeleg_i  (hedeleg_i),
        .to_s_o     (to_s),
        .to_vs_o    (to_vs)
    );

    trap_state_next #(.HYP_EN(HYP_EN)) u_nxt (
        .to_s_i     (to_s),
        .to_vs_i    (to_vs),
        .priv_i     (priv_i),
        .virt_i     (virt_eff),
        .force_hs_i (force_hs_i),
        .st_i       (st_i),
        .priv_o     (priv_nx),
        .virt_o     (virt_nx),
        .force_hs_o (force_nx),
        .st_o       (st_nx),
        .swap_o     (swap_nx)
    );

    // Commit all results together on the trap strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o     <= 1'b0;
            swap_o     <= 1'b0;
            cause_o    <= '0;
            priv_o     <= PRIV_M;
            virt_o     <= 1'b0;
            force_hs_o <= 1'b0;
            st_o       <= '0;
        end else if (trap_valid_i) begin
            done_o     <= 1'b1;
            swap_o     <= swap_nx;
            cause_o    <= word;
            priv_o     <= priv_nx;
            virt_o     <= virt_nx;
            force_hs_o <= force_nx;
            st_o       <= st_nx;
        end else begin
            done_o     <= 1'b0;
            swap_o     <= 1'b0;
        end
    end

endmodule

// File: rtl/trap_route_chk.sv
// Property checker for the trap routing unit, attached through bind.
// Assumes the port names of trap_route_unit.
module trap_route_chk #(
    parameter int XLEN    = 64,
    parameter int CAUSE_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trap_valid_i,
    input logic               async_i,
    input logic [CAUSE_W-1:0] cause_i,
    input logic [1:0]         priv_i,
    input logic               done_o,
    input logic               swap_o,
    input logic [1:0]         priv_o,
    input logic               virt_o,
    input logic [XLEN-1:0]    cause_o
);

    p_done_follows_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_i |=> done_o);

    p_idle_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid_i |=> !done_o);

    p_swap_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        swap_o |-> done_o);

    p_hold_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(priv_o) && $stable(virt_o) && $stable(cause_o)));

    p_guest_is_s_r5: assert property (@(posedge clk) disable iff (!rst_n)
        virt_o |-> (priv_o == 2'd1));

    p_swap_exits_guest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        swap_o |-> !virt_o);

    p_mcall_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && !async_i && cause_i == CAUSE_W'(8) && priv_i == 2'd3)
        |=> (cause_o[CAUSE_W-1:0] == CAUSE_W'(11)));

    p_class_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_i |=> (cause_o[XLEN-1] == $past(async_i)));

endmodule

bind trap_route_unit trap_route_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trap_valid_i (trap_valid_i),
    .async_i      (async_i),
    .cause_i      (cause_i),
    .priv_i       (priv_i),
    .done_o       (done_o),
    .swap_o       (swap_o),
    .priv_o       (priv_o),
    .virt_o       (virt_o),
    .cause_o      (cause_o)
);

// File: tb/sim_trap_route_unit.sv
`timescale 1ns/1ps
module sim_trap_route_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tv = 1'b0;
    logic        as = 1'b0;
    logic [7:0]  ca = '0;
    logic [1:0]  pv = 2'd3;
    logic        vi = 1'b0;
    logic        fi = 1'b0;
    logic [63:0] mid = '0, med = '0, hid = '0, hed = '0;
    logic [12:0] sti = '0;

    logic        d0, d1, s0, s1, v0, v1, f0, f1;
    logic [63:0] c0, c1;
    logic [1:0]  p0, p1;
    logic [12:0] t0, t1;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    trap_route_unit #(.XLEN(64), .CAUSE_W(8), .HYP_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .trap_valid_i(tv), .async_i(as), .cause_i(ca),
        .priv_i(pv), .virt_i(vi), .force_hs_i(fi), .mideleg_i(mid), .medeleg_i(med),
        .hideleg_i(hid), .hedeleg_i(hed), .st_i(sti), .done_o(d0), .cause_o(c0),
        .priv_o(p0), .virt_o(v0), .force_hs_o(f0), .st_o(t0), .swap_o(s0));

    trap_route_unit #(.XLEN(64), .CAUSE_W(8), .HYP_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .trap_valid_i(tv), .async_i(as), .cause_i(ca),
        .priv_i(pv), .virt_i(vi), .force_hs_i(fi), .mideleg_i(mid), .medeleg_i(med),
        .hideleg_i(hid), .hedeleg_i(hed), .st_i(sti), .done_o(d1), .cause_o(c1),
        .priv_o(p1), .virt_o(v1), .force_hs_o(f1), .st_o(t1), .swap_o(s1));

    // Expected {cause, priv, virt, force, status, swap} from the requirements.
    function automatic logic [81:0] model(input bit h, input bit a, input logic [7:0] ci,
            input logic [1:0] p, input bit v, input bit f, input logic [63:0] mi,
            input logic [63:0] me, input logic [63:0] hi, input logic [63:0] he,
            input logic [12:0] s_in);
        logic [7:0] c; logic [63:0] cw, m, hm; logic [1:0] np; logic [12:0] s;
        bit nv, nf, sw, ve, tos;
        c = ci; ve = h && v;
        if (!a && ci == 8) begin
            if (p == 3) c = 11; else if (p == 1) c = ve ? 8'd10 : 8'd9;
        end
        cw = 64'(c); cw[63] = a;
        m = a ? mi : me; hm = a ? hi : he;
        tos = (p <= 1) && (c < 64) && m[c[5:0]];
        s = s_in; sw = 0; nv = 0; nf = h ? f : 1'b0; np = p;
        if (tos) begin
            if (ve && hm[c[5:0]] && !f) nv = 1;
            else if (h) begin
                s[10] = s_in[9]; s[11] = s_in[2]; s[9] = ve;
                if (ve) begin s[12] = f; sw = 1; nf = 0; end
            end
            s[1] = s_in[0]; s[2] = (p == 1); np = 1;
        end else begin
            if (h) begin sw = ve; s[7] = ve; s[8] = f; end
            s[4] = s_in[3]; s[6:5] = p; np = 3;
        end
        return {cw, np, nv, nf, s, sw};
    endfunction

    function automatic string tag_of(input bit a, input logic [7:0] ci, input logic [1:0] p,
            input bit v, input bit f, input logic [63:0] mi, input logic [63:0] me,
            input logic [63:0] hi, input logic [63:0] he);
        logic [7:0] c; logic [63:0] m, hm; string t;
        c = ci;
        if (!a && ci == 8) c = (p == 3) ? 8'd11 : (p == 1) ? (v ? 8'd10 : 8'd9) : 8'd8;
        m = a ? mi : me; hm = a ? hi : he;
        t = (!a && ci == 8) ? "R2 R3 R12 " : "R3 R12 ";
        if ((p <= 1) && (c < 64) && m[c[5:0]]) begin
            if (v && hm[c[5:0]] && !f) t = {t, "R4 R5/R8"};
            else if (v) t = {t, "R4 R6/R8"};
            else t = {t, "R4 R7/R8"};
        end else t = {t, "R4 R9"};
        return t;
    endfunction

    task automatic chk(input string tag, input logic [81:0] act, input logic [81:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Present one trap, then compare both instances one edge later.
    task automatic apply(input bit a, input logic [7:0] ci, input logic [1:0] p, input bit v,
            input bit f, input logic [63:0] mi, input logic [63:0] me, input logic [63:0] hi,
            input logic [63:0] he, input logic [12:0] s_in);
        as = a; ca = ci; pv = p; vi = v; fi = f; mid = mi; med = me; hid = hi; hed = he;
        sti = s_in; tv = 1'b1;
        @(negedge clk);
        tv = 1'b0;
        chk(tag_of(a, ci, p, v, f, mi, me, hi, he), {c0, p0, v0, f0, t0, s0},
            model(1'b1, a, ci, p, v, f, mi, me, hi, he, s_in));
        chk("R11", {c1, p1, v1, f1, t1, s1},
            model(1'b0, a, ci, p, v, f, mi, me, hi, he, s_in));
        chk("R10 done", {80'd0, d0, d1}, {80'd0, 2'b11});
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [81:0] held;
        void'($urandom(20240611));
        repeat (3) @(negedge clk);
        // R1: reset values.
        chk("R1", {c0, p0, v0, f0, t0, s0, d0}, {64'd0, 2'd3, 1'b0, 1'b0, 13'd0, 1'b0, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases.
        apply(0, 8, 0, 0, 0, '0, '0, '0, '0, 13'h0005);           // R2 from U
        apply(0, 8, 1, 0, 0, '0, '0, '0, '0, 13'h0201);           // R2 from HS
        apply(0, 8, 1, 1, 0, '0, '0, '0, '0, 13'h0204);           // R2 from VS, to M with swap
        apply(0, 8, 3, 0, 1, '1, '1, '1, '1, 13'h0008);           // R2 from M
        apply(0, 63, 1, 0, 0, '0, 64'h8000_0000_0000_0000, '0, '0, 13'h0001); // R4 top index
        apply(0, 64, 0, 0, 0, '1, '1, '1, '1, 13'h0008);          // R4 out of range
        apply(1, 5, 1, 1, 0, 64'h20, '0, 64'h20, '0, 13'h0001);   // R5 stays in guest
        apply(1, 5, 1, 1, 1, 64'h20, '0, 64'h20, '0, 13'h0205);   // R6 force-HS override
        apply(1, 7, 3, 0, 0, '1, '1, '0, '0, 13'h0008);           // R9 from M
        apply(0, 8, 1, 1, 0, '0, 64'h400, 64'h0, 64'h400, 13'h0001); // R5 guest call kept

        // R10: results hold while idle and inputs move.
        held = {c0, p0, v0, f0, t0, s0};
        for (int i = 0; i < 4; i++) begin
            as = ~as; ca = ca + 8'd3; pv = 2'd0; vi = ~vi; sti = ~sti; mid = ~mid; med = ~med;
            @(negedge clk);
            chk("R10 hold", {c0, p0, v0, f0, t0, s0, d0}, {held, 1'b0});
        end

        // Random vectors mixed with sparse and dense masks.
        for (int n = 0; n < 1500; n++) begin
            int r; bit a, v, f; logic [7:0] c; logic [1:0] p; logic [63:0] m0, m1, m2, m3;
            r = $urandom_range(0, 2); p = (r == 2) ? 2'd3 : 2'(r);
            a = $urandom_range(0, 1);
            v = (p != 2'd3) ? 1'($urandom_range(0, 1)) : 1'b0;
            f = ($urandom_range(0, 3) == 0);
            r = $urandom_range(0, 9);
            c = (r < 3) ? 8'd8 : (r < 8) ? 8'($urandom_range(0, 15)) : 8'($urandom_range(0, 255));
            m0 = {$urandom, $urandom}; m1 = {$urandom, $urandom};
            m2 = {$urandom, $urandom}; m3 = {$urandom, $urandom};
            if ($urandom_range(0, 4) == 0) m0 = '1;
            if ($urandom_range(0, 4) == 0) m1 = '1;
            if ($urandom_range(0, 4) == 0) m2 = '0;
            apply(a, c, p, v, f, m0, m1, m2, m3, 13'($urandom));
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule